// File: doc/BRIEF.md
# SDRAM Read Burst Pipeline with Truncation

This block models the read data path on the device side of a synchronous DRAM. Each clock it takes either a READ or nothing, together with a bank and a column address. After a selectable CAS latency of two or three cycles it returns a burst of four data words from a small internal array. The column count within a burst steps through an aligned group of four and wraps inside it.

A READ may arrive on any cycle, including the cycle right after another READ. When a READ arrives while an earlier burst is still going, the earlier burst stops. The new burst's first word comes out on the cycle right after the last word the earlier burst had already put out, so the output stream has no gaps. The array is filled through a simple one-word write port. Between bursts the output-valid flag is low and the data bus reads zero, which stands in for a released bus.

Top module: `sdram_rd_pipe`

## Requirements
- R1: While rst_ni is low and after its release, until the first word of a READ is due, dq_valid_o is 0 and dq_o is 0.
- R2: With cl3_i = 0 the latency is 2; with cl3_i = 1 it is 3. A READ sampled at rising edge k loads its first word on edge k+CL-1, so the word is valid when sampled at edge k+CL.
- R3: A READ at bank b, column c returns four words on consecutive cycles. Word i, with i from 0 to 3, comes from bank b, column {c[COL_W-1:2], (c[1:0]+i) mod 4}.
- R4: A READ is accepted on every cycle, with no two-cycle spacing rule. A READ sampled j cycles after the previous one, with j from 1 to 3, cuts that burst to its first j words. Its own first word follows them on the next cycle.
- R5: A READ sampled exactly 4 cycles after the previous one leaves that burst complete, and its first word follows the fourth word with no idle cycle. A larger spacing leaves idle cycles between the bursts.
- R6: In any cycle with no burst word due, dq_valid_o is 0 and dq_o is 0.
- R7: Each READ may name any bank, including the bank of the READ just before it, and the bank and column apply to that burst only.
- R8: With wr_en_i high at a rising edge, wr_data_i is stored at (wr_bank_i, wr_col_i). A later READ returns the new word.
- R9: cl3_i may change while no burst is pending. READs sampled after the change use the new latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cl3_i | input | 1 | Latency select: 0 gives CL=2, 1 gives CL=3 |
| rd_i | input | 1 | READ command for this cycle (0 means no operation) |
| bank_i | input | BANK_W | Bank of the READ |
| col_i | input | COL_W | Start column of the READ |
| wr_en_i | input | 1 | Array write enable |
| wr_bank_i | input | BANK_W | Bank of the array write |
| wr_col_i | input | COL_W | Column of the array write |
| wr_data_i | input | DATA_W | Word to write |
| dq_o | output | DATA_W | Read data; zero when no word is valid |
| dq_valid_o | output | 1 | Read data valid |

## Verification
On every cycle, the assertions check that the output is zero whenever it is not valid. They also check that every READ is followed by a valid word exactly CL cycles later, that a new run of valid words always starts CL cycles after a READ, and that the output goes idle once CL+3 cycles have passed without a READ. Only the bench's scenarios can show the data itself: the column wrap order, which words survive a cut at each position of the burst, the seamless handoff at spacings 1 to 4 for both latencies, and the effect of a rewritten array word.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;
  localparam int unsigned MIN_CL = 2;
  localparam int unsigned MAX_CL = 3;

  typedef enum logic {
    LAT_2 = 1'b0,
    LAT_3 = 1'b1
  } lat_e;

  // delay-line tap holding a command that has waited CL-1 edges
  function automatic int unsigned lat_tap(lat_e lat);
    return (lat == LAT_3) ? (MAX_CL - 2) : (MIN_CL - 2);
  endfunction
endpackage

// File: rtl/sdram_rd_cmd_dly.sv
module sdram_rd_cmd_dly
  import sdram_rd_pkg::*;
#(
  parameter int unsigned TAG_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  lat_e             lat_i,
  input  logic             vld_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             vld_o,
  output logic [TAG_W-1:0] tag_o
);
  localparam int unsigned NSTG = MAX_CL - 1;

  logic [NSTG-1:0]  vld_q;
  logic [TAG_W-1:0] tag_q [NSTG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int s = 0; s < NSTG; s++) tag_q[s] <= '0;
    end else begin
      vld_q[0] <= vld_i;
      tag_q[0] <= tag_i;
      for (int s = 1; s < NSTG; s++) begin
        vld_q[s] <= vld_q[s-1];
        tag_q[s] <= tag_q[s-1];
      end
    end
  end

  always_comb begin
    vld_o = 1'b0;
    tag_o = '0;
    for (int s = 0; s < NSTG; s++) begin
      if (lat_tap(lat_i) == s) begin
        vld_o = vld_q[s];
        tag_o = tag_q[s];
      end
    end
  end
endmodule

// File: rtl/sdram_rd_burst.sv
module sdram_rd_burst #(
  parameter int unsigned BANK_W    = 2,
  parameter int unsigned COL_W     = 4,
  parameter int unsigned BURST_LEN = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic [BANK_W-1:0] launch_bank_i,
  input  logic [COL_W-1:0]  launch_col_i,
  output logic              emit_o,
  output logic [BANK_W-1:0] emit_bank_o,
  output logic [COL_W-1:0]  emit_col_o
);
  localparam int unsigned IDX_W = $clog2(BURST_LEN);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(BURST_LEN - 1);

  logic              act_q;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  col_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  lo_sum;

  assign lo_sum = col_q[IDX_W-1:0] + idx_q;

  // a launch always wins: this is the truncation point
  always_comb begin
    emit_o      = 1'b0;
    emit_bank_o = bank_q;
    emit_col_o  = col_q;
    if (launch_i) begin
      emit_o      = 1'b1;
      emit_bank_o = launch_bank_i;
      emit_col_o  = launch_col_i;
    end else if (act_q) begin
      emit_o     = 1'b1;
      emit_col_o = {col_q[COL_W-1:IDX_W], lo_sum};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      bank_q <= '0;
      col_q  <= '0;
      idx_q  <= '0;
    end else if (launch_i) begin
      act_q  <= 1'b1;
      bank_q <= launch_bank_i;
      col_q  <= launch_col_i;
      idx_q  <= IDX_W'(1);
    end else if (act_q) begin
      idx_q <= idx_q + 1'b1;
      if (idx_q == LAST) act_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sdram_rd_array.sv
module sdram_rd_array #(
  parameter int unsigned BANK_W = 2,
  parameter int unsigned COL_W  = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [BANK_W-1:0] wr_bank_i,
  input  logic [COL_W-1:0]  wr_col_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [BANK_W-1:0] rd_bank_i,
  input  logic [COL_W-1:0]  rd_col_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned DEPTH = 2 ** (BANK_W + COL_W);

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[{wr_bank_i, wr_col_i}] <= wr_data_i;
  end

  assign rd_data_o = mem_q[{rd_bank_i, rd_col_i}];
endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe
  import sdram_rd_pkg::*;
#(
  parameter int unsigned BANK_W    = 2,
  parameter int unsigned COL_W     = 4,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned BURST_LEN = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cl3_i,
  input  logic              rd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              wr_en_i,
  input  logic [BANK_W-1:0] wr_bank_i,
  input  logic [COL_W-1:0]  wr_col_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_valid_o
);
  localparam int unsigned TAG_W = BANK_W + COL_W;

  lat_e              lat;
  logic              launch;
  logic [TAG_W-1:0]  launch_tag;
  logic              emit;
  logic [BANK_W-1:0] emit_bank;
  logic [COL_W-1:0]  emit_col;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] dq_q;
  logic              vld_q;

  assign lat = lat_e'(cl3_i);

  sdram_rd_cmd_dly #(.TAG_W(TAG_W)) i_cmd_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lat_i  (lat),
    .vld_i  (rd_i),
    .tag_i  ({bank_i, col_i}),
    .vld_o  (launch),
    .tag_o  (launch_tag)
  );

  sdram_rd_burst #(
    .BANK_W    (BANK_W),
    .COL_W     (COL_W),
    .BURST_LEN (BURST_LEN)
  ) i_burst (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .launch_i      (launch),
    .launch_bank_i (launch_tag[TAG_W-1:COL_W]),
    .launch_col_i  (launch_tag[COL_W-1:0]),
    .emit_o        (emit),
    .emit_bank_o   (emit_bank),
    .emit_col_o    (emit_col)
  );

  sdram_rd_array #(
    .BANK_W (BANK_W),
    .COL_W  (COL_W),
    .DATA_W (DATA_W)
  ) i_array (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en_i),
    .wr_bank_i (wr_bank_i),
    .wr_col_i  (wr_col_i),
    .wr_data_i (wr_data_i),
    .rd_bank_i (emit_bank),
    .rd_col_i  (emit_col),
    .rd_data_o (rd_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      dq_q  <= '0;
    end else begin
      vld_q <= emit;
      dq_q  <= emit ? rd_word : '0;
    end
  end

  assign dq_o       = dq_q;
  assign dq_valid_o = vld_q;
endmodule

// File: rtl/sdram_rd_pipe_chk.sv
module sdram_rd_pipe_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cl3_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] dq_o,
  input logic              dq_valid_o
);
  // cycles since the last READ, saturating
  logic [2:0] quiet_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              quiet_q <= 3'd7;
    else if (rd_i)            quiet_q <= 3'd0;
    else if (quiet_q != 3'd7) quiet_q <= quiet_q + 3'd1;
  end

  a_r6_idle_bus_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dq_valid_o |-> (dq_o == '0));

  a_r2_first_word_cl2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !cl3_i) |-> ##2 dq_valid_o);

  a_r2_first_word_cl3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && cl3_i) |-> ##3 dq_valid_o);

  a_r2_start_needs_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dq_valid_o) |-> (cl3_i ? $past(rd_i, 3) : $past(rd_i, 2)));

  a_r3_burst_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet_q > (cl3_i ? 3'd5 : 3'd4)) |-> !dq_valid_o);
endmodule

bind sdram_rd_pipe sdram_rd_pipe_chk #(.DATA_W(DATA_W)) i_sdram_rd_pipe_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cl3_i      (cl3_i),
  .rd_i       (rd_i),
  .dq_o       (dq_o),
  .dq_valid_o (dq_valid_o)
);

// File: tb/test_sdram_rd_pipe.sv
`timescale 1ns/1ps
module test_sdram_rd_pipe;
  localparam int BANK_W = 2;
  localparam int COL_W  = 4;
  localparam int DATA_W = 8;
  localparam int NWORD  = 2 ** (BANK_W + COL_W);
  localparam int HIST   = 4096;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cl3_i = 1'b0;
  logic              rd_i = 1'b0;
  logic [BANK_W-1:0] bank_i = '0;
  logic [COL_W-1:0]  col_i = '0;
  logic              wr_en_i = 1'b0;
  logic [BANK_W-1:0] wr_bank_i = '0;
  logic [COL_W-1:0]  wr_col_i = '0;
  logic [DATA_W-1:0] wr_data_i = '0;
  logic [DATA_W-1:0] dq_o;
  logic              dq_valid_o;

  sdram_rd_pipe i_sdram_rd_pipe (.*);

  always #2.5 clk_i = ~clk_i;

  bit                h_rd   [HIST];
  logic [BANK_W-1:0] h_bank [HIST];
  logic [COL_W-1:0]  h_col  [HIST];
  logic [DATA_W-1:0] shadow [NWORD];

  int    cyc = 0;
  int    n_tests = 0;
  int    n_fail = 0;
  bit    chk_en = 0;
  bit    done = 0;
  int    cur_cl = 2;
  string cur_req = "R1";

  always @(posedge clk_i) begin
    if (rst_ni) begin
      if (cyc < HIST) begin
        h_rd[cyc]   = rd_i;
        h_bank[cyc] = bank_i;
        h_col[cyc]  = col_i;
      end
      cyc = cyc + 1;
    end
  end

  // reference: newest READ no later than edge p-(CL-1), at most 3 words back
  always @(negedge clk_i) begin
    if (chk_en && cyc > 0 && !done) begin
      int p, q, wi;
      bit ev, hit;
      logic [BANK_W-1:0] b;
      logic [COL_W-1:0]  c, ec;
      logic [DATA_W-1:0] ed;
      p = cyc - 1;
      q = p - (cur_cl - 1);
      hit = 0; wi = 0; b = '0; c = '0;
      for (int d = 0; d < 4; d++) begin
        if (!hit && (q - d) >= 0 && (q - d) < HIST && h_rd[q-d]) begin
          hit = 1; wi = d; b = h_bank[q-d]; c = h_col[q-d];
        end
      end
      ev = hit;
      ec = {c[COL_W-1:2], 2'(c[1:0] + 2'(wi))};
      ed = ev ? shadow[{b, ec}] : '0;
      n_tests++;
      if (dq_valid_o !== ev || dq_o !== ed) begin
        n_fail++;
        $display("FAIL %s edge %0d: valid=%0b data=%02h expected valid=%0b data=%02h",
                 ev ? cur_req : "R6", p, dq_valid_o, dq_o, ev, ed);
      end
    end
  end

  task automatic step(input bit rd, input int b, input int c);
    rd_i   = rd;
    bank_i = BANK_W'(b);
    col_i  = COL_W'(c);
    @(negedge clk_i);
  endtask

  task automatic idle(input int n);
    repeat (n) step(0, 0, 0);
  endtask

  task automatic wr(input int b, input int c, input logic [DATA_W-1:0] v);
    wr_en_i   = 1'b1;
    wr_bank_i = BANK_W'(b);
    wr_col_i  = COL_W'(c);
    wr_data_i = v;
    shadow[{BANK_W'(b), COL_W'(c)}] = v;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < HIST; i++) h_rd[i] = 0;
    repeat (3) @(negedge clk_i);
    n_tests++;  // R1 during reset
    if (dq_valid_o !== 1'b0 || dq_o !== '0) begin
      n_fail++;
      $display("FAIL R1 in reset: valid=%0b data=%02h expected valid=0 data=00", dq_valid_o, dq_o);
    end
    rst_ni = 1'b1;
    cur_req = "R1";
    chk_en = 1;
    // R8: fill the array through the write port
    for (int b = 0; b < 4; b++)
      for (int c = 0; c < 16; c++)
        wr(b, c, DATA_W'((b * 37 + c * 11 + 5) & 8'hFF));
    idle(4);

    for (int l = 0; l < 2; l++) begin
      cl3_i  = l[0];
      cur_cl = 2 + l;
      idle(8);
      // R2 R3 R9: single bursts from every start column
      cur_req = "R2 R3 R9";
      for (int c = 0; c < 16; c++) begin
        step(1, c % 4, c);
        idle(8);
      end
      // R4 R5: cut at each position and the seamless handoff, every start phase
      cur_req = "R4 R5";
      for (int s = 0; s < 4; s++)
        for (int m = 1; m <= 6; m++) begin
          step(1, s, 4 + s);
          idle(m - 1);
          step(1, (s + 1) % 4, 8 + ((s + m) % 4));
          idle(8);
        end
      // R4 R7: a READ on every cycle, banks repeating
      cur_req = "R4 R7";
      for (int i = 0; i < 12; i++) step(1, (i / 2) % 4, (i * 5) % 16);
      idle(8);
      // R7: same bank back to back at spacing 4 and 1
      cur_req = "R7 R5";
      step(1, 2, 1); idle(3); step(1, 2, 13); idle(3); step(1, 2, 6); step(1, 2, 7);
      idle(8);
    end

    // R8: overwrite one word, then read it back in a burst
    cur_req = "R8";
    wr(3, 5, 8'h5A);
    idle(2);
    step(1, 3, 4);
    idle(8);
    step(1, 3, 6);
    idle(8);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule